// File: doc/BRIEF.md
# Four-Way Tree Pseudo-LRU Victim Selector

This block keeps the replacement history of a 4-way set-associative cache. For every set index it stores three bits arranged as a binary tree. The root bit picks one pair of ways, and each of the two leaf bits picks one way inside its own pair. The cache reports each access with a strobe, the set index and the way that was used. The tree of that set is then updated so that it points away from the way just used.

A second, independent index port asks which way should be evicted next from a given set. The answer is decoded combinationally from the stored tree bits, so it is valid in the same cycle the index is presented. The number of sets is a parameter. Tag compare, data arrays and line fill are left to the surrounding cache.

Top module: `plru_tree_sel`

## Requirements
- R1: After reset every set holds tree bits root=0, low-leaf=0, high-leaf=0, so the victim reported for every index is way 0.
- R2: When the root bit of the requested set is 0, the victim is way 0 if the low-leaf bit is 0 and way 1 if it is 1, whatever the high-leaf bit holds.
- R3: When the root bit of the requested set is 1, the victim is way 2 if the high-leaf bit is 0 and way 3 if it is 1, whatever the low-leaf bit holds.
- R4: An access to way 0 sets root=1 and low-leaf=1. An access to way 1 sets root=1 and low-leaf=0. In both cases the high-leaf bit keeps its value.
- R5: An access to way 2 sets root=0 and high-leaf=1. An access to way 3 sets root=0 and high-leaf=0. In both cases the low-leaf bit keeps its value.
- R6: Right after an access, the victim of that set lies in the pair (ways 0-1 or ways 2-3) that does not contain the accessed way.
- R7: A set's tree changes only at a clock edge where the strobe is high and the access index equals that set. A way value presented with the strobe low, or an access to another index, leaves the set's victim unchanged.
- R8: The victim output follows the request index combinationally. An update shows up on it from the cycle after the access edge.
- R9: Starting from reset, accesses to ways 0, 1, 2 and 3 of one set, in that order, leave way 0 as that set's victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe; updates the tree of `acc_idx` |
| acc_idx | input | IDX_W | Set index of the access |
| acc_way | input | 2 | Way that was accessed |
| req_idx | input | IDX_W | Set index whose victim is requested |
| victim_way | output | 2 | Way to replace in set `req_idx` |

## Verification
The bench keeps a model of every set's tree. It drives a deterministic spread of accesses through all sets, so every leaf is hit while its sibling leaf holds each value. A design that updated the wrong leaf, or cleared the untouched leaf, would later name a victim in the wrong half of the pair. After each access it reads a different set and repeats a strobe-low cycle carrying a new way. An update leaking across indexes, or a write that ignored the strobe, then shows up as a moved victim. The reset sweep and the 0-1-2-3 sequence catch a tree that starts at a non-zero value or a root bit with inverted sense.

// File: rtl/plru_pkg.sv
package plru_pkg;

  // bit 0: root, bit 1: low-pair leaf, bit 2: high-pair leaf
  typedef logic [2:0] plru_tree_t;
  typedef logic [1:0] plru_way_t;

  localparam plru_tree_t PLRU_RESET = 3'b000;

  // Victim: root selects the pair, the pair's leaf selects the way.
  function automatic plru_way_t plru_victim(input plru_tree_t t);
    plru_way_t w;
    w[1] = t[0];
    w[0] = t[0] ? t[2] : t[1];
    return w;
  endfunction

  // Update: root points to the other pair, leaf points to the sibling way.
  function automatic plru_tree_t plru_touch(input plru_tree_t t, input plru_way_t w);
    plru_tree_t n;
    n    = t;
    n[0] = ~w[1];
    if (w[1]) n[2] = ~w[0];
    else      n[1] = ~w[0];
    return n;
  endfunction

endpackage

// File: rtl/plru_store.sv
module plru_store
  import plru_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  plru_tree_t       wr_data,
  input  logic [IDX_W-1:0] rda_idx,
  output plru_tree_t       rda_data,
  input  logic [IDX_W-1:0] rdb_idx,
  output plru_tree_t       rdb_data
);

  plru_tree_t trees_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        trees_q[s] <= PLRU_RESET;
      end else if (wr_en && (wr_idx == IDX_W'(s))) begin
        trees_q[s] <= wr_data;
      end
    end
  end

  always_comb begin
    rda_data = PLRU_RESET;
    rdb_data = PLRU_RESET;
    for (int s = 0; s < SETS; s++) begin
      if (rda_idx == IDX_W'(s)) rda_data = trees_q[s];
      if (rdb_idx == IDX_W'(s)) rdb_data = trees_q[s];
    end
  end

endmodule

// File: rtl/plru_update.sv
module plru_update
  import plru_pkg::*;
(
  input  plru_tree_t cur_tree,
  input  plru_way_t  used_way,
  output plru_tree_t next_tree
);

  assign next_tree = plru_touch(cur_tree, used_way);

endmodule

// File: rtl/plru_decode.sv
module plru_decode
  import plru_pkg::*;
(
  input  plru_tree_t tree,
  output plru_way_t  way
);

  assign way = plru_victim(tree);

endmodule

// File: rtl/plru_tree_sel.sv
module plru_tree_sel
  import plru_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic [1:0]       acc_way,
  input  logic [IDX_W-1:0] req_idx,
  output logic [1:0]       victim_way
);

  // Named internal events for the checker
  plru_tree_t acc_tree;   // stored tree of the accessed set
  plru_tree_t acc_next;   // tree to be written
  plru_tree_t req_tree;   // stored tree of the requested set
  logic       upd_fire;

  assign upd_fire = acc_valid;

  plru_store #(.SETS(SETS), .IDX_W(IDX_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (upd_fire),
    .wr_idx   (acc_idx),
    .wr_data  (acc_next),
    .rda_idx  (acc_idx),
    .rda_data (acc_tree),
    .rdb_idx  (req_idx),
    .rdb_data (req_tree)
  );

  plru_update u_update (
    .cur_tree  (acc_tree),
    .used_way  (acc_way),
    .next_tree (acc_next)
  );

  plru_decode u_decode (
    .tree (req_tree),
    .way  (victim_way)
  );

endmodule

// File: rtl/plru_tree_sel_chk.sv
module plru_tree_sel_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic [IDX_W-1:0] acc_idx,
  input logic [1:0]       acc_way,
  input logic [IDX_W-1:0] req_idx,
  input logic [1:0]       victim_way,
  input logic [2:0]       req_tree
);

  a_r1_reset_zero: assert property (@(posedge clk)
    $rose(rst_n) |-> (req_tree == 3'b000) && (victim_way == 2'd0));

  a_r2_low_pair_decode: assert property (@(posedge clk) disable iff (!rst_n)
    !req_tree[0] |-> (!victim_way[1] && (victim_way[0] == req_tree[1])));

  a_r3_high_pair_decode: assert property (@(posedge clk) disable iff (!rst_n)
    req_tree[0] |-> (victim_way[1] && (victim_way[0] == req_tree[2])));

  a_r4_low_touch: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_way[1] && (req_idx == acc_idx)) ##1 $stable(req_idx)
    |-> req_tree[0] && (req_tree[1] == !$past(acc_way[0]))
        && (req_tree[2] == $past(req_tree[2])));

  a_r5_high_touch: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_way[1] && (req_idx == acc_idx)) ##1 $stable(req_idx)
    |-> !req_tree[0] && (req_tree[2] == !$past(acc_way[0]))
        && (req_tree[1] == $past(req_tree[1])));

  a_r6_other_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (req_idx == acc_idx)) ##1 $stable(req_idx)
    |-> victim_way[1] != $past(acc_way[1]));

  a_r7_no_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid || (acc_idx != req_idx)) ##1 $stable(req_idx)
    |-> $stable(req_tree));

endmodule

bind plru_tree_sel plru_tree_sel_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_idx    (acc_idx),
  .acc_way    (acc_way),
  .req_idx    (req_idx),
  .victim_way (victim_way),
  .req_tree   (req_tree)
);

// File: tb/tb_plru_tree_sel.sv
`timescale 1ns/1ps
module tb_plru_tree_sel;

  localparam int SETS  = 16;
  localparam int IDX_W = 4;

  logic             clk = 0;
  logic             rst_n = 0;
  logic             acc_valid = 0;
  logic [IDX_W-1:0] acc_idx = '0;
  logic [1:0]       acc_way = '0;
  logic [IDX_W-1:0] req_idx = '0;
  logic [1:0]       victim_way;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [2:0] mdl [SETS];

  always #2.5 clk = ~clk;

  plru_tree_sel #(.SETS(SETS), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_idx(acc_idx),
    .acc_way(acc_way), .req_idx(req_idx), .victim_way(victim_way)
  );

  // Model, written as a lookup over the 3-bit state {high, low, root}
  function automatic logic [1:0] exp_victim(input logic [2:0] s);
    case (s)
      3'b000: return 2'd0;
      3'b010: return 2'd1;
      3'b100: return 2'd0;
      3'b110: return 2'd1;
      3'b001: return 2'd2;
      3'b011: return 2'd2;
      3'b101: return 2'd3;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [2:0] exp_touch(input logic [2:0] s, input logic [1:0] w);
    case (w)
      2'd0: return {s[2], 1'b1, 1'b1};
      2'd1: return {s[2], 1'b0, 1'b1};
      2'd2: return {1'b1, s[1], 1'b0};
      default: return {1'b0, s[1], 1'b0};
    endcase
  endfunction

  task automatic check(input string tag, input logic [1:0] got, input logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: victim=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic look(input int idx, input string tag);
    req_idx = IDX_W'(idx);
    #1;
    check(tag, victim_way, exp_victim(mdl[idx]));
  endtask

  task automatic access(input int idx, input logic [1:0] w, input bit strobe);
    @(negedge clk);
    acc_valid = strobe;
    acc_idx   = IDX_W'(idx);
    acc_way   = w;
    req_idx   = IDX_W'(idx);
    @(posedge clk);
    if (strobe) mdl[idx] = exp_touch(mdl[idx], w);
    @(negedge clk);
    acc_valid = 0;
  endtask

  initial begin
    for (int i = 0; i < SETS; i++) mdl[i] = 3'b000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: every set reports way 0 after reset
    for (int i = 0; i < SETS; i++) look(i, "R1");

    // R9: ways 0,1,2,3 in order on set 5
    for (int w = 0; w < 4; w++) access(5, 2'(w), 1'b1);
    req_idx = IDX_W'(5);
    #1;
    check("R9", victim_way, 2'd0);

    // Sweep: every set, many accesses
    for (int s = 0; s < 24; s++) begin
      for (int i = 0; i < SETS; i++) begin
        logic [1:0] w;
        logic [1:0] alt;
        w   = 2'((i * 7 + s * 3 + (s >> 2)) % 4);
        alt = 2'((i + s * 5 + 1) % 4);
        access(i, w, 1'b1);
        #1;
        // R8: update visible in the cycle after the access edge
        // R4 / R5: leaf and root rules, checked via the victim
        check(w[1] ? "R5" : "R4", victim_way, exp_victim(mdl[i]));
        // R2 / R3: decode by root bit
        check(mdl[i][0] ? "R3" : "R2", victim_way, exp_victim(mdl[i]));
        // R6: victim in the opposite pair
        checks++;
        if (victim_way[1] == w[1]) begin
          errors++;
          $display("FAIL R6: victim=%0d expected pair %0d", victim_way, !w[1]);
        end
        // R7: neighbour set unaffected (R8: combinational read)
        look((i + 1) % SETS, "R7");
        look((i + 9) % SETS, "R8");
        // R7: strobe low with another way leaves the set alone
        access(i, alt, 1'b0);
        look(i, "R7");
      end
    end

    // R1: reset again restores way 0 everywhere
    @(negedge clk);
    rst_n = 0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < SETS; i++) mdl[i] = 3'b000;
    for (int i = 0; i < SETS; i++) look(i, "R1");

    done = 1;
  end

  initial begin : watchdog
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected completion", cyc);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule